// File: doc/BRIEF.md
# Fault-Aware Interval Counter

This block is a timer counter that runs either as a down counter or as an up/down (triangle) counter. It takes a start value and a repeat setting, and it either reloads at zero or stops there. An external fault line is brought into the clock domain through a synchronizer. A policy input picks whether the fault is ignored or freezes the count. For the freezing case, a resume policy picks the value the counter restarts from when the fault clears: the held count, the start value, or zero.

The enable input gates all counting. While enable is low the counter parks at its starting point: the load value in down mode, zero in up/down mode. The fault logic never touches enable, so software keeps enable high for the whole time a fault policy is in force. A one-cycle zero event marks each arrival at zero produced by counting. A status output shows the synchronized fault level.

Top module: `fault_timer`

## Requirements
- R1: While `rst` is high, `count` is 0, `zero_evt` is 0 and `fault_active` is 0 after each clock edge.
- R2: On every edge with `en` low, `count` takes `load_val` when `updown_mode` is 0 and takes 0 when `updown_mode` is 1. `zero_evt` is 0 after such an edge.
- R3: In down mode (`updown_mode` = 0) the count drops by one per edge. At zero, `repeat_mode` codes 1 and 3 reload `load_val` on the next edge. Codes 0 and 2 hold the count at zero.
- R4: In up/down mode (`updown_mode` = 1) the count rises by one per edge from 0 until it equals `load_val`, then falls by one per edge to 0. At zero while falling, `repeat_mode` codes 1 and 3 start a new rise (next value 1). Codes 0 and 2 hold the count at zero.
- R5: `zero_evt` is high for exactly the cycle after an edge on which counting moved the count from a nonzero value to 0. It is never set by holding at zero, by a frozen edge, or by a resume action.
- R6: `fault_active` equals `fault_in` as sampled two clock edges earlier.
- R7: With `fault_freeze` = 0 the count advances exactly as in R3/R4, whatever `fault_active` is.
- R8: With `fault_freeze` = 1, every edge on which `fault_active` is high leaves `count` unchanged.
- R9: With `fault_freeze` = 1 and `fault_resume` = 0, the first edge with `fault_active` low after a high period performs a normal count step from the held value.
- R10: With `fault_freeze` = 1, `fault_resume` = 1 and `resume_sel` = 0, that first edge loads `load_val` and starts a falling count.
- R11: With `fault_freeze` = 1, `fault_resume` = 1 and `resume_sel` = 1 or 3, that first edge keeps the held count, and counting resumes on the following edge.
- R12: With `fault_freeze` = 1, `fault_resume` = 1 and `resume_sel` = 2, that first edge sets the count to 0 with a rising direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counter enable |
| fault_in | input | 1 | Asynchronous fault line |
| load_val | input | WIDTH | Period / start value |
| updown_mode | input | 1 | 0 down count, 1 up/down count |
| repeat_mode | input | 2 | Codes 1 and 3 repeat at zero, codes 0 and 2 stop |
| fault_freeze | input | 1 | 1 freezes the count during a fault |
| fault_resume | input | 1 | 1 applies `resume_sel` on fault exit |
| resume_sel | input | 2 | Resume value: 0 load, 1/3 held, 2 zero |
| count | output | WIDTH | Current count |
| zero_evt | output | 1 | One-cycle pulse on arrival at zero |
| fault_active | output | 1 | Synchronized fault level |

## Verification
The bench sweeps every combination of mode, repeat code, freeze bit, resume bit and resume selector. Each combination gets its own load value and its own fault window, and the bench compares against an arithmetic model on every cycle. The exit edge is the sharpest corner. A design that counted on that edge under the held-value selector would run one count ahead. A design that failed to count there under the plain continue policy would run one count behind. Other targets are a reload that keeps a stale direction in up/down mode, a zero event raised by a resume to zero or while parked at zero, and freezing with one synchronizer stage too few, which would stop the count a cycle early.

// File: rtl/fault_timer_pkg.sv
package fault_timer_pkg;
  // resume selector codes (code 3 behaves as held value)
  localparam logic [1:0] RESUME_LOAD = 2'd0;
  localparam logic [1:0] RESUME_HELD = 2'd1;
  localparam logic [1:0] RESUME_ZERO = 2'd2;

  // counting direction
  localparam logic DIR_DOWN = 1'b0;
  localparam logic DIR_UP   = 1'b1;

  function automatic logic repeat_on(input logic [1:0] code);
    return (code == 2'd1) || (code == 2'd3);
  endfunction
endpackage

// File: rtl/fault_timer_sync.sv
module fault_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fault_timer_policy.sv
module fault_timer_policy (
  input  logic clk,
  input  logic rst,
  input  logic flt_sync,
  input  logic freeze_en,
  input  logic resume_en,
  output logic freeze,
  output logic exit_edge,
  output logic resume_act
);
  logic flt_prev;

  always_ff @(posedge clk) begin
    if (rst) flt_prev <= 1'b0;
    else     flt_prev <= flt_sync;
  end

  assign freeze     = freeze_en & flt_sync;
  assign exit_edge  = flt_prev & ~flt_sync;
  assign resume_act = freeze_en & resume_en & exit_edge;
endmodule

// File: rtl/fault_timer_step.sv
module fault_timer_step
  import fault_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             dir_up,
  input  logic [WIDTH-1:0] load_val,
  input  logic             updown_mode,
  input  logic [1:0]       repeat_mode,
  output logic [WIDTH-1:0] nxt_cnt,
  output logic             nxt_up,
  output logic             hits_zero
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic rpt;
  assign rpt = repeat_on(repeat_mode);

  always_comb begin
    nxt_cnt = cnt;
    nxt_up  = dir_up;
    if (!updown_mode) begin
      if (cnt == '0) nxt_cnt = rpt ? load_val : '0;
      else           nxt_cnt = cnt - ONE;
    end else if (dir_up == DIR_UP) begin
      if (cnt >= load_val) begin
        nxt_up  = DIR_DOWN;
        nxt_cnt = (cnt == '0) ? '0 : cnt - ONE;
      end else begin
        nxt_cnt = cnt + ONE;
      end
    end else begin
      if (cnt == '0) begin
        if (rpt) begin
          nxt_up  = DIR_UP;
          nxt_cnt = ONE;
        end
      end else begin
        nxt_cnt = cnt - ONE;
      end
    end
    hits_zero = (nxt_cnt == '0) && (cnt != '0);
  end
endmodule

// File: rtl/fault_timer.sv
module fault_timer
  import fault_timer_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fault_in,
  input  logic [WIDTH-1:0] load_val,
  input  logic             updown_mode,
  input  logic [1:0]       repeat_mode,
  input  logic             fault_freeze,
  input  logic             fault_resume,
  input  logic [1:0]       resume_sel,
  output logic [WIDTH-1:0] count,
  output logic             zero_evt,
  output logic             fault_active
);
  logic             flt_sync;
  logic             freeze;
  logic             exit_edge;
  logic             resume_act;
  logic             cnt_up;
  logic [WIDTH-1:0] nxt_cnt;
  logic             nxt_up;
  logic             hits_zero;

  fault_timer_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (fault_in),
    .q   (flt_sync)
  );

  assign fault_active = flt_sync;

  fault_timer_policy policy_i (
    .clk        (clk),
    .rst        (rst),
    .flt_sync   (flt_sync),
    .freeze_en  (fault_freeze),
    .resume_en  (fault_resume),
    .freeze     (freeze),
    .exit_edge  (exit_edge),
    .resume_act (resume_act)
  );

  fault_timer_step #(.WIDTH(WIDTH)) step_i (
    .cnt         (count),
    .dir_up      (cnt_up),
    .load_val    (load_val),
    .updown_mode (updown_mode),
    .repeat_mode (repeat_mode),
    .nxt_cnt     (nxt_cnt),
    .nxt_up      (nxt_up),
    .hits_zero   (hits_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      cnt_up   <= DIR_UP;
      zero_evt <= 1'b0;
    end else if (!en) begin
      count    <= updown_mode ? '0 : load_val;
      cnt_up   <= DIR_UP;
      zero_evt <= 1'b0;
    end else if (freeze) begin
      zero_evt <= 1'b0;
    end else if (resume_act) begin
      zero_evt <= 1'b0;
      case (resume_sel)
        RESUME_LOAD: begin
          count  <= load_val;
          cnt_up <= DIR_DOWN;
        end
        RESUME_ZERO: begin
          count  <= '0;
          cnt_up <= DIR_UP;
        end
        default: ;
      endcase
    end else begin
      count    <= nxt_cnt;
      cnt_up   <= nxt_up;
      zero_evt <= hits_zero;
    end
  end

  // R8: a fault seen with freezing enabled holds the count
  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (en && fault_freeze && fault_active) |=> $stable(count));

  // R10: resume to the load value
  p_resume_load_r10: assert property (@(posedge clk) disable iff (rst)
    (en && resume_act && resume_sel == RESUME_LOAD) |=> (count == $past(load_val)));

  // R11: resume keeps the held count for one edge
  p_resume_held_r11: assert property (@(posedge clk) disable iff (rst)
    (en && resume_act && resume_sel[0]) |=> $stable(count));

  // R12: resume to zero
  p_resume_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (en && resume_act && resume_sel == RESUME_ZERO) |=> (count == '0));

  // R5: the event only ever accompanies a zero count and lasts one cycle
  p_zero_at_zero_r5: assert property (@(posedge clk) disable iff (rst)
    zero_evt |-> (count == '0));
  p_zero_single_r5: assert property (@(posedge clk) disable iff (rst)
    zero_evt |=> !zero_evt);

  // R2: no event while disabled
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> !zero_evt);

  // R9: resume events only on a fault exit
  p_resume_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
    resume_act |-> (exit_edge && !fault_active));
endmodule

// File: tb/fault_timer_tb.sv
module fault_timer_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic         fault_in = 1'b0;
  logic [W-1:0] load_val = '0;
  logic         updown_mode = 1'b0;
  logic [1:0]   repeat_mode = '0;
  logic         fault_freeze = 1'b0;
  logic         fault_resume = 1'b0;
  logic [1:0]   resume_sel = '0;
  logic [W-1:0] count;
  logic         zero_evt;
  logic         fault_active;

  always #10 clk = ~clk; // 50 MHz

  fault_timer #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst (rst), .en (en), .fault_in (fault_in),
    .load_val (load_val), .updown_mode (updown_mode),
    .repeat_mode (repeat_mode), .fault_freeze (fault_freeze),
    .fault_resume (fault_resume), .resume_sel (resume_sel),
    .count (count), .zero_evt (zero_evt), .fault_active (fault_active)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  logic [W-1:0] m_cnt;
  logic         m_up;
  logic         m_z;
  logic         m_s1, m_s2, m_q;
  string        m_tag;

  always @(posedge clk) begin
    logic fall, frz, ract, rpt;
    logic [W-1:0] nc;
    logic nu;
    if (rst) begin
      m_cnt = '0; m_up = 1'b1; m_z = 1'b0;
      m_s1 = 1'b0; m_s2 = 1'b0; m_q = 1'b0;
      m_tag = "R1";
    end else begin
      fall = m_q && !m_s2;
      frz  = fault_freeze && m_s2;
      ract = fault_freeze && fault_resume && fall;
      rpt  = (repeat_mode == 2'd1) || (repeat_mode == 2'd3);
      if (!en) begin
        m_cnt = updown_mode ? '0 : load_val; m_up = 1'b1; m_z = 1'b0; m_tag = "R2";
      end else if (frz) begin
        m_z = 1'b0; m_tag = "R8";
      end else if (ract) begin
        m_z = 1'b0;
        if (resume_sel == 2'd0) begin
          m_cnt = load_val; m_up = 1'b0; m_tag = "R10";
        end else if (resume_sel == 2'd2) begin
          m_cnt = '0; m_up = 1'b1; m_tag = "R12";
        end else begin
          m_tag = "R11";
        end
      end else begin
        nc = m_cnt; nu = m_up;
        if (!updown_mode) begin           // R3 down count
          nc = (m_cnt == 0) ? (rpt ? load_val : '0) : m_cnt - 1'b1;
        end else if (m_up) begin          // R4 rising
          if (m_cnt >= load_val) begin nu = 1'b0; nc = m_cnt - 1'b1; end
          else nc = m_cnt + 1'b1;
        end else if (m_cnt == 0) begin    // R4 bottom
          if (rpt) begin nu = 1'b1; nc = 1; end
        end else begin
          nc = m_cnt - 1'b1;
        end
        m_z = (nc == 0) && (m_cnt != 0);  // R5
        m_cnt = nc; m_up = nu;
        if (!fault_freeze && m_s2)  m_tag = "R7";
        else if (fault_freeze && fall) m_tag = "R9";
        else m_tag = updown_mode ? "R4" : "R3";
      end
      m_q = m_s2; m_s2 = m_s1; m_s1 = fault_in;   // R6
    end
  end

  task automatic check_outputs();
    n_checks++;
    if (count !== m_cnt) begin
      n_fail++;
      $display("FAIL %s count: actual %0d expected %0d", m_tag, count, m_cnt);
    end
    n_checks++;
    if (zero_evt !== m_z) begin
      n_fail++;
      $display("FAIL R5 zero_evt (%s): actual %0b expected %0b", m_tag, zero_evt, m_z);
    end
    n_checks++;
    if (fault_active !== m_s2) begin
      n_fail++;
      $display("FAIL R6 fault_active: actual %0b expected %0b", fault_active, m_s2);
    end
  endtask

  initial begin
    for (int c = 0; c < 128; c++) begin
      int f_on, f_len;
      updown_mode  = c[0];
      repeat_mode  = c[2:1];
      fault_freeze = c[3];
      fault_resume = c[4];
      resume_sel   = c[6:5];
      load_val     = W'(3 + (c % 4));
      f_on  = 6 + (c % 7);
      f_len = 3 + (c % 4);
      // R1: reset state
      rst = 1'b1; en = 1'b0; fault_in = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        check_outputs();
      end
      rst = 1'b0;
      for (int cyc = 0; cyc < 40; cyc++) begin
        @(negedge clk);
        check_outputs();
        en = (cyc >= 2);                                   // R2 idle, then run
        fault_in = (cyc >= f_on) && (cyc < f_on + f_len);  // R6..R12
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule